// File: doc/BRIEF.md
# External Bus Cycle Generator for a Microcontroller Emulator

This block turns the internal bus requests of a CPU core into the signals of an external memory and I/O bus. It runs on the oscillator clock and splits every machine cycle into two oscillator phases. The first is an address phase, in which the data bus is always an input. The second is a data phase, in which the data strobe is high. A request is presented with its address, its direction, an opcode-fetch flag and the space decode of the core: internal space, internal RAM, or an unused page-0 I/O location. The block places the request on the bus two machine cycles later.

A mode input selects early address timing. When it is low, the address, the read strobe and the fetch status line up with the data transfer, and the read strobe only fires together with chip enable. This lets standard memories connect directly. When it is high, the address, read and fetch status run one machine cycle ahead of the transfer, so that external break and trace logic can latch them. Read then becomes a full-cycle read/write indicator for every cycle, internal or external, and the internal RAM space is sent off-chip. In both modes chip enable and write enable stay aligned with the transfer. A halt input models the wait and stop states: it freezes the machine cycle and silences the strobe. The mode input should be tied low when it is unused.

Top module: `bus_cycle_gen`

## Requirements
- R1: While reset is high, and in the cycle after it, the outputs are idle: ce_n, rd_n and we_n are 1, and fs, ds, db_oe and bus_addr are 0. Any request presented during reset is ignored.
- R2: ds is 0 in the first oscillator phase of every machine cycle and 1 in the second, so it alternates on every clock. While halt is 1, ds is 0 and the phase, the pipeline, we_n and db_oe are frozen or idle. After halt is released, the cycle resumes in the phase where it stopped.
- R3: A request is sampled on the clock edge that ends a machine cycle, which is an edge where ds is 1. Its transfer occupies the machine cycle after next. With early_mode at 0, bus_addr and fs show the transfer request during both phases of that cycle.
- R4: With early_mode at 1, bus_addr, fs and rd_n show the request that will be transferred in the following machine cycle, one machine cycle ahead of its transfer.
- R5: ce_n is 0 for the whole transfer machine cycle of every request that goes off-chip, and 1 otherwise, in both modes. A request goes off-chip when it is not internal, or when it is internal RAM and early_mode is 1.
- R6: we_n is 0 only in the second phase of the transfer cycle of an off-chip write (req_rd=0), so it is always gated with ce_n, in both modes.
- R7: With early_mode at 0, rd_n is 0 only during the transfer cycle of an off-chip read (req_rd=1), and only while ce_n is 0.
- R8: With early_mode at 1, rd_n is low for one full machine cycle ahead of every read transfer, internal or external, and high ahead of writes and idle cycles. It is not gated by ce_n.
- R9: An internal RAM request (req_internal=1, req_ram=1) stays on-chip (ce_n=1) when early_mode is 0 and goes off-chip when early_mode is 1. Other internal requests never assert ce_n.
- R10: A request flagged as an unused page-0 location never asserts ce_n or we_n, but its address is still driven on bus_addr.
- R11: db_oe is 0 in the first phase of every machine cycle. In the second phase it is 1 unless the transfer is an off-chip read, which includes driving the bus during reads of internal space.
- R12: fs is 1 exactly when the request shown on bus_addr is an opcode fetch (req_fetch=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; two clocks form one machine cycle |
| rst | input | 1 | Synchronous active-high reset |
| early_mode | input | 1 | 1 selects early address timing and off-chip RAM |
| halt | input | 1 | Wait/stop state: freezes the machine cycle |
| req_valid | input | 1 | Request carries a bus access |
| req_addr | input | 13 | Request address |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_fetch | input | 1 | Request is an opcode fetch |
| req_internal | input | 1 | Address decodes to on-chip space |
| req_ram | input | 1 | Address decodes to the on-chip RAM range |
| req_unused | input | 1 | Address is an unused page-0 I/O location |
| bus_addr | output | 13 | External address |
| ce_n | output | 1 | Chip enable, active low |
| rd_n | output | 1 | Read strobe or read/write status, active low |
| we_n | output | 1 | Write enable pulse, active low |
| fs | output | 1 | Fetch status |
| ds | output | 1 | Data strobe, high in the second phase |
| db_oe | output | 1 | 1 = chip drives the data bus |

## Verification
The properties assume that early_mode changes only while the pipeline holds idle requests, because a change in the middle of a RAM transfer would legally move ce_n within a cycle. They also assume that halt is asserted only when no request is in flight. The stimulus changes the mode only at the start of each vector, when both pipeline stages hold idle requests, and it raises halt only after the table has drained. It also keeps each request's space flags consistent: a request is never both unused and RAM.

// File: rtl/bus_cycle_gen_pkg.sv
package bus_cycle_gen_pkg;

    localparam int BUS_ADDR_W = 13;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic                  valid;
        logic                  rd;
        logic                  fetch;
        logic                  internal;
        logic                  ram;
        logic                  unused;
        logic [BUS_ADDR_W-1:0] addr;
    } bus_req_t;

    localparam bus_req_t IDLE_REQ = '0;

    // A request leaves the chip unless it targets an unused slot, or it is
    // internal and not remapped (RAM goes off-chip only in early mode).
    function automatic logic goes_offchip(bus_req_t r, logic early);
        return r.valid && !r.unused && (!r.internal || (early && r.ram));
    endfunction

endpackage

// File: rtl/bcg_phase.sv
module bcg_phase
    import bus_cycle_gen_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   halt,
    output phase_e ph,
    output logic   ds,
    output logic   cyc_end
);

    phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= PH_ADDR;
        else if (!halt)
            ph_q <= (ph_q == PH_ADDR) ? PH_DATA : PH_ADDR;
    end

    assign ph      = ph_q;
    assign ds      = (ph_q == PH_DATA) && !halt;
    assign cyc_end = (ph_q == PH_DATA) && !halt;

endmodule

// File: rtl/bcg_req_pipe.sv
module bcg_req_pipe
    import bus_cycle_gen_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cyc_end,
    input  logic                  early,
    input  bus_req_t              req_in,
    output bus_req_t              cur_q,
    output logic                  lead_valid,
    output logic                  lead_rd,
    output logic                  lead_fetch,
    output logic [BUS_ADDR_W-1:0] lead_addr
);

    bus_req_t nxt_q;
    bus_req_t cur_r;
    bus_req_t lead;

    // Stage 1 holds the lookahead request, stage 2 the transfer request.
    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_q <= IDLE_REQ;
            cur_r <= IDLE_REQ;
        end else if (cyc_end) begin
            nxt_q <= req_in;
            cur_r <= nxt_q;
        end
    end

    always_comb begin
        lead = early ? nxt_q : cur_r;
    end

    assign cur_q      = cur_r;
    assign lead_valid = lead.valid;
    assign lead_rd    = lead.rd;
    assign lead_fetch = lead.fetch;
    assign lead_addr  = lead.addr;

endmodule

// File: rtl/bcg_decode.sv
module bcg_decode
    import bus_cycle_gen_pkg::*;
(
    input  logic                  early,
    input  logic                  halt,
    input  phase_e                ph,
    input  bus_req_t              cur,
    input  logic                  lead_valid,
    input  logic                  lead_rd,
    input  logic                  lead_fetch,
    input  logic [BUS_ADDR_W-1:0] lead_addr,
    output logic [BUS_ADDR_W-1:0] bus_addr,
    output logic                  ce_n,
    output logic                  rd_n,
    output logic                  we_n,
    output logic                  fs,
    output logic                  db_oe
);

    logic ext_cur;
    logic data_ph;
    logic ext_read;

    always_comb begin
        ext_cur  = goes_offchip(cur, early);
        data_ph  = (ph == PH_DATA) && !halt;
        ext_read = ext_cur && cur.rd;

        bus_addr = lead_addr;
        fs       = lead_valid && lead_fetch;
        ce_n     = !ext_cur;
        we_n     = !(ext_cur && !cur.rd && data_ph);
        if (early)
            rd_n = !(lead_valid && lead_rd);
        else
            rd_n = !ext_read;
        db_oe    = data_ph && !ext_read;
    end

endmodule

// File: rtl/bus_cycle_gen.sv
module bus_cycle_gen
    import bus_cycle_gen_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  early_mode,
    input  logic                  halt,
    input  logic                  req_valid,
    input  logic [BUS_ADDR_W-1:0] req_addr,
    input  logic                  req_rd,
    input  logic                  req_fetch,
    input  logic                  req_internal,
    input  logic                  req_ram,
    input  logic                  req_unused,
    output logic [BUS_ADDR_W-1:0] bus_addr,
    output logic                  ce_n,
    output logic                  rd_n,
    output logic                  we_n,
    output logic                  fs,
    output logic                  ds,
    output logic                  db_oe
);

    phase_e                ph;
    logic                  cyc_end;
    bus_req_t              req_in;
    bus_req_t              cur_req;
    logic                  lead_valid;
    logic                  lead_rd;
    logic                  lead_fetch;
    logic [BUS_ADDR_W-1:0] lead_addr;

    always_comb begin
        req_in.valid    = req_valid;
        req_in.rd       = req_rd;
        req_in.fetch    = req_fetch;
        req_in.internal = req_internal;
        req_in.ram      = req_ram;
        req_in.unused   = req_unused;
        req_in.addr     = req_addr;
    end

    bcg_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .halt    (halt),
        .ph      (ph),
        .ds      (ds),
        .cyc_end (cyc_end)
    );

    bcg_req_pipe u_pipe (
        .clk        (clk),
        .rst        (rst),
        .cyc_end    (cyc_end),
        .early      (early_mode),
        .req_in     (req_in),
        .cur_q      (cur_req),
        .lead_valid (lead_valid),
        .lead_rd    (lead_rd),
        .lead_fetch (lead_fetch),
        .lead_addr  (lead_addr)
    );

    bcg_decode u_decode (
        .early      (early_mode),
        .halt       (halt),
        .ph         (ph),
        .cur        (cur_req),
        .lead_valid (lead_valid),
        .lead_rd    (lead_rd),
        .lead_fetch (lead_fetch),
        .lead_addr  (lead_addr),
        .bus_addr   (bus_addr),
        .ce_n       (ce_n),
        .rd_n       (rd_n),
        .we_n       (we_n),
        .fs         (fs),
        .db_oe      (db_oe)
    );

endmodule

// File: rtl/bus_cycle_gen_chk.sv
module bus_cycle_gen_chk (
    input logic clk,
    input logic rst,
    input logic early_mode,
    input logic halt,
    input logic ce_n,
    input logic rd_n,
    input logic we_n,
    input logic fs,
    input logic ds,
    input logic db_oe,
    input logic cur_valid,
    input logic cur_rd,
    input logic cur_unused
);

    logic live;

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (ce_n && rd_n && we_n && !fs && !ds && !db_oe)); // R1

    AST_DS_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        (live && !halt && !$past(halt)) |-> (ds != $past(ds))); // R2

    AST_CE_WHOLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (live && ds) |-> $stable(ce_n)); // R5

    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ce_n); // R6

    AST_WE_DATA_PHASE: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> ds); // R6

    AST_RD_GATED_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (!early_mode && !rd_n) |-> !ce_n); // R7

    AST_RD_FULL_CYCLE_EARLY: assert property (@(posedge clk) disable iff (rst)
        (live && early_mode && $past(early_mode) && ds) |-> $stable(rd_n)); // R8

    AST_UNUSED_NO_CE: assert property (@(posedge clk) disable iff (rst)
        (cur_valid && cur_unused) |-> (ce_n && we_n)); // R10

    AST_BUS_INPUT_FIRST: assert property (@(posedge clk) disable iff (rst)
        !ds |-> !db_oe); // R11

    AST_NO_DRIVE_EXT_READ: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && cur_rd) |-> !db_oe); // R11

endmodule

bind bus_cycle_gen bus_cycle_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .early_mode (early_mode),
    .halt       (halt),
    .ce_n       (ce_n),
    .rd_n       (rd_n),
    .we_n       (we_n),
    .fs         (fs),
    .ds         (ds),
    .db_oe      (db_oe),
    .cur_valid  (cur_req.valid),
    .cur_rd     (cur_req.rd),
    .cur_unused (cur_req.unused)
);

// File: tb/bus_cycle_gen_test.sv
`timescale 1ns/1ps
module bus_cycle_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        early_mode = 1'b0;
    logic        halt = 1'b0;
    logic        req_valid = 1'b0;
    logic [12:0] req_addr = '0;
    logic        req_rd = 1'b0;
    logic        req_fetch = 1'b0;
    logic        req_internal = 1'b0;
    logic        req_ram = 1'b0;
    logic        req_unused = 1'b0;
    logic [12:0] bus_addr;
    logic        ce_n, rd_n, we_n, fs, ds, db_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    bus_cycle_gen uut (
        .clk(clk), .rst(rst), .early_mode(early_mode), .halt(halt),
        .req_valid(req_valid), .req_addr(req_addr), .req_rd(req_rd),
        .req_fetch(req_fetch), .req_internal(req_internal), .req_ram(req_ram),
        .req_unused(req_unused), .bus_addr(bus_addr), .ce_n(ce_n), .rd_n(rd_n),
        .we_n(we_n), .fs(fs), .ds(ds), .db_oe(db_oe)
    );

    typedef struct packed {
        logic        early;
        logic        rd;
        logic        fetch;
        logic        internal;
        logic        ram;
        logic        unused;
        logic [12:0] addr;
        logic        exp_ext;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 13'h1234, 1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0ABC, 1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 13'h0080, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 13'h0010, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 13'h001F, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 13'h1FFF, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 13'h00C0, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 13'h00FF, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 13'h0005, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 13'h001C, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0F0F, 1'b1}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_req(input logic v, input logic rd, input logic fe, input logic in,
                           input logic ram, input logic un, input logic [12:0] a);
        req_valid = v; req_rd = rd; req_fetch = fe; req_internal = in;
        req_ram = ram; req_unused = un; req_addr = a;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset with a live request and early mode, outputs must stay idle
        early_mode = 1'b1;
        set_req(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 13'h1555);
        step(); step(); step();
        check("R1 ce_n", ce_n, 1);   check("R1 rd_n", rd_n, 1);
        check("R1 we_n", we_n, 1);   check("R1 fs", fs, 0);
        check("R1 ds", ds, 0);       check("R1 db_oe", db_oe, 0);
        check("R1 bus_addr", bus_addr, 0);
        early_mode = 1'b0;
        set_req(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0);
        rst = 1'b0;

        // Table walk: request captured at the second edge, transfer two cycles on
        for (int i = 0; i < NVEC; i++) begin
            vec_t  v;
            string cetag;
            v = VECS[i];
            cetag = v.unused ? "R10 ce_n" : (v.internal ? "R9 ce_n" : "R5 ce_n");
            early_mode = v.early;
            set_req(1'b1, v.rd, v.fetch, v.internal, v.ram, v.unused, v.addr);
            step();                      // first phase -> second phase
            step();                      // edge ending the cycle: request sampled
            set_req(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0);
            // lookahead cycle, first phase
            check("R2 ds low", ds, 0);
            check("R5 ce_n idle", ce_n, 1);
            if (v.early) begin
                check("R4 addr", bus_addr, v.addr);
                check("R8 rd_n", rd_n, !v.rd);
                check("R12 fs", fs, v.fetch);
            end else begin
                check("R7 rd_n", rd_n, 1);
                check("R3 fs", fs, 0);
            end
            step();
            // lookahead cycle, second phase
            check("R2 ds high", ds, 1);
            check("R5 ce_n idle", ce_n, 1);
            check("R11 db_oe idle", db_oe, 1);
            if (v.early) check("R8 rd_n held", rd_n, !v.rd);
            step();
            // transfer cycle, first phase
            check("R2 ds low", ds, 0);
            check(cetag, ce_n, !v.exp_ext);
            check("R11 db_oe first", db_oe, 0);
            check("R6 we_n first", we_n, 1);
            if (!v.early) begin
                check("R3 addr", bus_addr, v.addr);
                check("R12 fs", fs, v.fetch);
                check("R7 rd_n", rd_n, !(v.rd && v.exp_ext));
            end else begin
                check("R4 addr", bus_addr, 0);
                check("R8 rd_n", rd_n, 1);
            end
            step();
            // transfer cycle, second phase
            check(cetag, ce_n, !v.exp_ext);
            check("R6 we_n", we_n, !(v.exp_ext && !v.rd));
            check("R11 db_oe", db_oe, !(v.exp_ext && v.rd));
            if (!v.early) check("R7 rd_n", rd_n, !(v.rd && v.exp_ext));
            step();
        end

        // R4: back-to-back in early mode, address runs one cycle ahead of CE
        early_mode = 1'b1;
        set_req(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 13'h0111);
        step(); step();
        set_req(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0222);
        step(); step();
        set_req(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0);
        check("R4 addr ahead", bus_addr, 13'h0222);
        check("R5 ce_n read", ce_n, 0);
        check("R8 rd_n write ahead", rd_n, 1);
        check("R12 fs ahead", fs, 0);
        step();
        check("R11 db_oe ext read", db_oe, 0);
        check("R6 we_n read", we_n, 1);
        step();
        check("R5 ce_n write", ce_n, 0);
        step();
        check("R6 we_n write", we_n, 0);
        check("R11 db_oe write", db_oe, 1);
        step(); step(); step();
        early_mode = 1'b0;

        // R2: halt freezes the machine cycle and silences the strobe
        check("R2 ds before halt", ds, 0);
        halt = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            check("R2 ds halted", ds, 0);
            check("R2 db_oe halted", db_oe, 0);
        end
        halt = 1'b0;
        check("R2 ds resumed phase", ds, 0);
        step();
        check("R2 ds after halt", ds, 1);
        step();
        check("R2 ds toggles", ds, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule